// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This unit keeps a 64-bit signed running sum in two 32-bit halves. Each accepted command does one of three things. It can add the signed product of two 32-bit operands to the sum. It can subtract that product from the sum. Or it can read a 32-bit window of the sum and clear the sum in the same step. Every command completes in one clock. A command issued right after another therefore sees the updated sum, with no stall and no wait state.

Commands arrive on a valid/ready stream. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Readout values leave on a second valid/ready stream, which has a one-entry holding register. The unit lowers `cmd_ready` for two reasons. The first is a held readout result that is not being taken this cycle, so no further command is accepted until the consumer raises `res_ready`. The second is a direct write to an accumulator half in the same cycle, so the write wins and the command waits. A stalled command is neither applied nor lost. It stays on the stream until it is accepted.

A plain side port lets software write either half and read either half of the sum at any time. The read is combinational, so it shows the current register contents.

Top module: `mac_accum_unit`

## Requirements
- R1: After reset, both accumulator halves read 0, `res_valid` is 0, and `cmd_ready` is 1.
- R2: An accepted command with `cmd_op` = 2'b01 adds the signed 64-bit product `cmd_a` × `cmd_b` to the accumulator. Both operands are treated as two's complement.
- R3: An accepted command with `cmd_op` = 2'b10 subtracts the signed 64-bit product `cmd_a` × `cmd_b` from the accumulator.
- R4: An accepted command with `cmd_op` = 2'b11 raises `res_valid` on the next cycle. The value on `res_data` is accumulator bits 59:28 as they stood before the command, which equals the arithmetic right shift by 28 truncated to 32 bits.
- R5: The readout command (2'b11) sets both accumulator halves to zero in the same clock edge that captures the result.
- R6: Commands may be accepted on consecutive cycles. Each one operates on the accumulator value left by the one before it.
- R7: A direct write with `sr_wr_hi` = 0 loads bits 31:0, and one with `sr_wr_hi` = 1 loads bits 63:32. `sr_rd_data` shows bits 31:0 when `sr_rd_hi` = 0 and bits 63:32 when `sr_rd_hi` = 1.
- R8: While `sr_wr_en` is high, `cmd_ready` is 0 and no command changes the accumulator. The half that is not written keeps its value. The stalled command takes effect once it is accepted later.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_data` stays stable, `cmd_ready` is 0, and the accumulator does not change.
- R10: An accepted command with `cmd_op` = 2'b00 leaves the accumulator unchanged and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present on the stream |
| cmd_ready | output | 1 | Unit will take the command this cycle |
| cmd_op | input | 2 | 00 none, 01 add product, 10 subtract product, 11 readout and clear |
| cmd_a | input | 32 | First signed operand |
| cmd_b | input | 32 | Second signed operand |
| res_valid | output | 1 | Readout result held for the consumer |
| res_ready | input | 1 | Consumer takes the held result |
| res_data | output | 32 | Readout value, accumulator bits 59:28 |
| sr_wr_en | input | 1 | Direct write to one accumulator half |
| sr_wr_hi | input | 1 | Selects the written half: 0 low, 1 high |
| sr_wr_data | input | 32 | Value for the direct write |
| sr_rd_hi | input | 1 | Selects the read half: 0 low, 1 high |
| sr_rd_data | output | 32 | Current contents of the selected half |

## Verification
Two things can land in the same cycle. A direct write to an accumulator half can coincide with a pending add, and a held, unaccepted readout can coincide with a new command. The bench drives `sr_wr_en` and a multiply-add command together. It checks that `cmd_ready` falls, that only the written half changes, and that the add lands one cycle later on top of the written value. It then holds `res_ready` low after a readout while offering another command, and checks that the result stays stable, that the sum stays unchanged, and that both streams move on the same edge once `res_ready` rises.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  // Command encodings on cmd_op
  typedef enum logic [1:0] {
    MAC_OP_NONE = 2'b00,
    MAC_OP_ADD  = 2'b01,
    MAC_OP_SUB  = 2'b10,
    MAC_OP_READ = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
// Full-width signed product, computed in one combinational stage.
module mac_mult #(
  parameter int OPND_W = 32
) (
  input  logic [OPND_W-1:0]   op_a,
  input  logic [OPND_W-1:0]   op_b,
  output logic [2*OPND_W-1:0] prod
);
  localparam int PROD_W = 2 * OPND_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  // Sign-extend both operands so the truncated product is exact.
  assign a_ext = {{OPND_W{op_a[OPND_W-1]}}, op_a};
  assign b_ext = {{OPND_W{op_b[OPND_W-1]}}, op_b};

  always_comb begin
    prod = PROD_W'(a_ext * b_ext);
  end
endmodule

// File: rtl/mac_acc_core.sv
`timescale 1ns/1ps
// Accumulator held as two half-width registers. A direct write wins over a command.
module mac_acc_core
  import mac_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [1:0]          op,
  input  logic [2*OPND_W-1:0] prod,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [OPND_W-1:0]   wr_data,
  output logic [2*OPND_W-1:0] acc_q
);
  localparam int ACC_W  = 2 * OPND_W;
  localparam int N_HALF = 2;

  logic [OPND_W-1:0] half_q [N_HALF];
  logic [ACC_W-1:0]  acc_nxt;
  logic              cmd_go;

  assign cmd_go = fire && !wr_en;
  assign acc_q  = {half_q[1], half_q[0]};

  always_comb begin
    acc_nxt = acc_q;
    if (cmd_go) begin
      unique case (mac_op_e'(op))
        MAC_OP_ADD:  acc_nxt = acc_q + prod;
        MAC_OP_SUB:  acc_nxt = acc_q - prod;
        MAC_OP_READ: acc_nxt = '0;
        default:     acc_nxt = acc_q;
      endcase
    end
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam logic SEL = 1'(h);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        half_q[h] <= '0;
      end else if (wr_en && (wr_hi == SEL)) begin
        half_q[h] <= wr_data;
      end else begin
        half_q[h] <= acc_nxt[h*OPND_W +: OPND_W];
      end
    end
  end

  // R2: a multiply-add moves the sum by the product
  p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en && op == MAC_OP_ADD) |=> (acc_q == $past(acc_q) + $past(prod)));

  // R3: a multiply-subtract moves the sum down by the product
  p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en && op == MAC_OP_SUB) |=> (acc_q == $past(acc_q) - $past(prod)));

  // R5: readout leaves both halves at zero
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en && op == MAC_OP_READ) |=> (acc_q == '0));

  // R7: low-half write lands, R8: high half untouched
  p_wr_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (acc_q[OPND_W-1:0] == $past(wr_data)));
  p_wr_keep_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (acc_q[ACC_W-1:OPND_W] == $past(acc_q[ACC_W-1:OPND_W])));
  p_wr_keep_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (acc_q[OPND_W-1:0] == $past(acc_q[OPND_W-1:0])));

  // R10: no command or a no-op command keeps the sum
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (!fire || op == MAC_OP_NONE)) |=> $stable(acc_q));
endmodule

// File: rtl/mac_result_reg.sv
`timescale 1ns/1ps
// One-entry holding register on the readout stream.
module mac_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              slot_free
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= load_data;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign slot_free = !res_valid || res_ready;

  // R9: a held result neither changes nor disappears before it is taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: rtl/mac_accum_unit.sv
`timescale 1ns/1ps
module mac_accum_unit
  import mac_pkg::*;
#(
  parameter int OPND_W   = 32,
  parameter int RD_SHIFT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [OPND_W-1:0] cmd_a,
  input  logic [OPND_W-1:0] cmd_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [OPND_W-1:0] res_data,
  input  logic              sr_wr_en,
  input  logic              sr_wr_hi,
  input  logic [OPND_W-1:0] sr_wr_data,
  input  logic              sr_rd_hi,
  output logic [OPND_W-1:0] sr_rd_data
);
  localparam int ACC_W = 2 * OPND_W;

  logic [ACC_W-1:0]  prod;
  logic [ACC_W-1:0]  acc_q;
  logic [OPND_W-1:0] rd_field;
  logic              slot_free;
  logic              fire;
  logic              rd_load;

  assign cmd_ready = slot_free && !sr_wr_en;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_load   = fire && (mac_op_e'(cmd_op) == MAC_OP_READ);
  assign rd_field  = acc_q[RD_SHIFT +: OPND_W];

  assign sr_rd_data = sr_rd_hi ? acc_q[ACC_W-1:OPND_W] : acc_q[OPND_W-1:0];

  mac_mult #(.OPND_W(OPND_W)) u_mult (
    .op_a (cmd_a),
    .op_b (cmd_b),
    .prod (prod)
  );

  mac_acc_core #(.OPND_W(OPND_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .op      (cmd_op),
    .prod    (prod),
    .wr_en   (sr_wr_en),
    .wr_hi   (sr_wr_hi),
    .wr_data (sr_wr_data),
    .acc_q   (acc_q)
  );

  mac_result_reg #(.DATA_W(OPND_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load),
    .load_data (rd_field),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .slot_free (slot_free)
  );

  // R4: readout value is the shifted window of the sum before clearing
  p_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == MAC_OP_READ) |=>
      (res_valid && res_data == $past(acc_q[RD_SHIFT +: OPND_W])));

  // R9: a blocked result blocks the sum as well
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !sr_wr_en) |=> $stable(acc_q));
endmodule

// File: tb/mac_accum_unit_bench.sv
`timescale 1ns/1ps
module mac_accum_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_a = '0;
  logic [31:0] cmd_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;
  logic        sr_wr_en = 1'b0;
  logic        sr_wr_hi = 1'b0;
  logic [31:0] sr_wr_data = '0;
  logic        sr_rd_hi = 1'b0;
  logic [31:0] sr_rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mac_accum_unit u_mac_accum_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .sr_wr_en(sr_wr_en),
    .sr_wr_hi(sr_wr_hi), .sr_wr_data(sr_wr_data), .sr_rd_hi(sr_rd_hi),
    .sr_rd_data(sr_rd_data)
  );

  // Entry: {op, a, b, expected sum after, expected readout (op 11 only)}
  localparam int NV = 11;
  localparam logic [161:0] VEC [NV] = '{
    {2'b01, 32'd3,          32'd4,          64'h0000_0000_0000_000C, 32'h0},
    {2'b01, 32'hFFFF_FFFB,  32'd6,          64'hFFFF_FFFF_FFFF_FFEE, 32'h0},
    {2'b10, 32'hFFFF_FFF9,  32'hFFFF_FFF8,  64'hFFFF_FFFF_FFFF_FFB6, 32'h0},
    {2'b01, 32'h1000_0000,  32'h0000_0010,  64'h0000_0000_FFFF_FFB6, 32'h0},
    {2'b11, 32'd0,          32'd0,          64'h0,                   32'h0000_000F},
    {2'b10, 32'h4000_0000,  32'h0000_0040,  64'hFFFF_FFF0_0000_0000, 32'h0},
    {2'b00, 32'd9,          32'd9,          64'hFFFF_FFF0_0000_0000, 32'h0},
    {2'b11, 32'd0,          32'd0,          64'h0,                   32'hFFFF_FF00},
    {2'b01, 32'h8000_0000,  32'h8000_0000,  64'h4000_0000_0000_0000, 32'h0},
    {2'b01, 32'h8000_0000,  32'h7FFF_FFFF,  64'h0000_0000_8000_0000, 32'h0},
    {2'b11, 32'd0,          32'd0,          64'h0,                   32'h0000_0008}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_acc(output logic [63:0] v);
    sr_rd_hi = 1'b0;
    #0.2;
    v[31:0] = sr_rd_data;
    sr_rd_hi = 1'b1;
    #0.2;
    v[63:32] = sr_rd_data;
    sr_rd_hi = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the command is taken.
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] acc;
    repeat (3) @(negedge clk);
    // R1: reset state
    read_acc(acc);
    check(acc == 64'h0, "R1 sum at reset", acc, 64'h0);
    check(res_valid == 1'b0, "R1 res_valid at reset", 64'(res_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 cmd_ready after reset", 64'(cmd_ready), 64'h1);

    // R2 R3 R4 R5 R10: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  vop;
      logic [63:0] vacc;
      logic [31:0] vres;
      vop  = VEC[i][161:160];
      vacc = VEC[i][95:32];
      vres = VEC[i][31:0];
      issue(vop, VEC[i][159:128], VEC[i][127:96]);
      read_acc(acc);
      check(acc == vacc, (vop == 2'b10) ? "R3 sum after subtract" :
            (vop == 2'b11) ? "R5 sum after readout" :
            (vop == 2'b00) ? "R10 sum after no-op" : "R2 sum after add", acc, vacc);
      if (vop == 2'b11) begin
        check(res_valid && res_data == vres, "R4 readout value", 64'(res_data), 64'(vres));
      end else begin
        check(!res_valid, "R10 no result for non-readout", 64'(res_valid), 64'h0);
      end
    end

    // R7: direct write and read of both halves
    sr_wr_en = 1'b1; sr_wr_hi = 1'b0; sr_wr_data = 32'h1234_5678;
    @(posedge clk); @(negedge clk);
    sr_wr_hi = 1'b1; sr_wr_data = 32'h9ABC_DEF0;
    @(posedge clk); @(negedge clk);
    sr_wr_en = 1'b0;
    read_acc(acc);
    check(acc == 64'h9ABC_DEF0_1234_5678, "R7 direct half writes", acc, 64'h9ABC_DEF0_1234_5678);

    // Clear via readout, then R8: write and add offered together
    issue(2'b11, 0, 0);
    sr_wr_en = 1'b1; sr_wr_hi = 1'b0; sr_wr_data = 32'd5;
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 32'd2; cmd_b = 32'd3;
    #0.2;
    check(cmd_ready == 1'b0, "R8 ready low during direct write", 64'(cmd_ready), 64'h0);
    @(posedge clk); @(negedge clk);
    sr_wr_en = 1'b0;
    read_acc(acc);
    check(acc == 64'd5, "R8 write wins, add not applied", acc, 64'd5);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    read_acc(acc);
    check(acc == 64'd11, "R8 stalled add applied later", acc, 64'd11);

    // R9: result back-pressure against a new command
    sr_wr_en = 1'b1; sr_wr_hi = 1'b1; sr_wr_data = 32'd1;
    @(posedge clk); @(negedge clk);
    sr_wr_hi = 1'b0; sr_wr_data = 32'd0;
    @(posedge clk); @(negedge clk);
    sr_wr_en = 1'b0;
    res_ready = 1'b0;
    issue(2'b11, 0, 0);
    check(res_valid && res_data == 32'h10, "R4 readout of 2^32", 64'(res_data), 64'h10);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 32'd1; cmd_b = 32'd1;
    #0.2;
    check(cmd_ready == 1'b0, "R9 ready low while result held", 64'(cmd_ready), 64'h0);
    @(posedge clk); @(negedge clk);
    check(res_valid && res_data == 32'h10, "R9 result held stable", 64'(res_data), 64'h10);
    read_acc(acc);
    check(acc == 64'h0, "R9 sum frozen while blocked", acc, 64'h0);
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check(!res_valid, "R9 result taken", 64'(res_valid), 64'h0);
    read_acc(acc);
    check(acc == 64'd1, "R9 waiting add applied on release", acc, 64'd1);

    // R6: back-to-back commands with no gap
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 32'h1000_0000; cmd_b = 32'h30;
    @(posedge clk); @(negedge clk);
    cmd_op = 2'b11;
    @(posedge clk); @(negedge clk);
    check(res_valid && res_data == 32'h30, "R6 readout right after add",
          64'(res_data), 64'h30);
    cmd_op = 2'b01; cmd_a = 32'd2; cmd_b = 32'd2;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    read_acc(acc);
    check(acc == 64'd4, "R6 add right after clear", acc, 64'd4);

    // R1: reset with a non-zero sum
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    read_acc(acc);
    check(acc == 64'h0, "R1 reset clears sum", acc, 64'h0);
    rst_n = 1'b1;

    summary();
    $finish;
  end
endmodule